// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block collects up to sixteen peripheral interrupt lines for a small processor core, keeps a request register with one bit per line, and names the single line the core should service next. Every line carries three pieces of configuration: a two-bit priority code that places it at level 1, 2 or 3 (3 is the most urgent), an enable bit, and an assertion-type bit that says whether the peripheral pulses its line for one clock or holds it high until the peripheral itself is serviced. Above the three programmable levels sits a fixed group of two special requests, an illegal-instruction trap and a watchdog request, which are not latched and cannot be reprogrammed.

The core reads the result from a registered state machine with four states. IDLE means nothing is eligible, SOURCE means an ordinary line has won, WDOG means the watchdog has won and TRAP means the trap has won. Each clock the machine takes the transition to the most urgent state that is eligible: to TRAP when the trap input is high, else to WDOG when the watchdog request and its enable are both high, else to SOURCE when any enabled request bit is set, else to IDLE. The same transitions apply from every state. The core acknowledges an ordinary line with a one-cycle pulse that carries the line's index. Software can clear request bits with a one-cycle clear strobe and a bit mask, which acts as writing 0 to those bits. The assertion type decides what each of these does to a line's request bit.

Top module: `intc3_top`

## Requirements
- R1: While reset is low and on the first cycle after it, req_o is all zeros, irq_kind_o is 0, irq_idx_o is 0 and irq_pending_o is 0.
- R2: A pulse-type line (src_cont_i bit 0) that is high for one clock sets its req_o bit at the next edge, and the bit stays set with the line low until an acknowledge or a clear removes it.
- R3: An acknowledge (ack_i high, ack_idx_i equal to the line's index) clears the req_o bit of a pulse-type line at the next edge. The same acknowledge leaves the req_o bit of a continuous-type line (src_cont_i bit 1) set.
- R4: A clear strobe (clr_i high with the line's bit set in clr_bits_i) clears the req_o bit of a pulse-type line at the next edge.
- R5: A clear strobe on a continuous-type line whose input is still high makes its req_o bit read 0 for exactly one cycle, after which it reads 1 again.
- R6: A continuous-type bit stays set after its line drops and clears for good only after a clear strobe arrives while the line is low.
- R7: When a pulse-type line is high in the same cycle as an acknowledge or a clear strobe for that line, its req_o bit is set after the edge.
- R8: An enabled pending request at a higher level always wins over every request at a lower level. Priority codes 1, 2 and 3 map to levels 1, 2 and 3, and code 0 counts as level 1.
- R9: Among enabled pending requests at the same level, the lowest index wins.
- R10: A line whose src_en_i bit is 0 never wins, and its req_o bit is left as it was. When the enable returns, a still-pending request can win at the next edge.
- R11: The trap input wins over everything else (irq_kind_o = 3). The watchdog request wins over all ordinary lines only when wdt_en_i is 1 (irq_kind_o = 2). An ordinary winner gives irq_kind_o = 1, and no winner gives 0. irq_idx_o is the winning index when irq_kind_o is 1 and 0 otherwise. irq_pending_o is 1 whenever irq_kind_o is not 0.
- R12: irq_kind_o, irq_idx_o and irq_pending_o are registered. They follow a change to req_o, src_en_i, src_lvl_i, trap_i or the watchdog inputs one edge later, so a new pulse reaches them two edges after the line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | 16 | Peripheral request lines |
| src_cont_i | input | 16 | Per-line assertion type: 1 continuous, 0 pulse |
| src_en_i | input | 16 | Per-line enable |
| src_lvl_i | input | 32 | Two-bit priority code per line; line i uses bits 2i+1:2i |
| wdt_req_i | input | 1 | Watchdog request |
| wdt_en_i | input | 1 | Watchdog interrupt enable |
| trap_i | input | 1 | Illegal-instruction trap request |
| ack_i | input | 1 | One-cycle acknowledge from the core |
| ack_idx_i | input | 4 | Index of the acknowledged line |
| clr_i | input | 1 | One-cycle clear strobe |
| clr_bits_i | input | 16 | Bits to clear when clr_i is high |
| req_o | output | 16 | Request register contents |
| irq_pending_o | output | 1 | Some request is eligible |
| irq_kind_o | output | 2 | Winner class: 0 none, 1 line, 2 watchdog, 3 trap |
| irq_idx_o | output | 4 | Winning line index |

## Verification
The properties assume that src_cont_i stays fixed while a line is active, that a pulse-type line behaves as a one-cycle pulse, and that ack_idx_i names an ordinary line only while ack_i is high. The directed part of the stimulus changes assertion types only when the affected lines are quiet. The random part draws pulse-type lines as independent single cycles, keeps the type mask fixed, and rarely toggles the continuous lines, enables, priority codes and special requests. The behavioural model in the bench follows every one of these changes, so in this design the assumptions only shape which cases are likely to occur.

// File: rtl/intc3_pkg.sv
package intc3_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_SOURCE = 2'b01,
        ST_WDOG   = 2'b10,
        ST_TRAP   = 2'b11
    } intc3_state_e;

    localparam int LVL_W = 2;

    // priority code 0 is folded onto the lowest level
    function automatic logic [LVL_W-1:0] eff_level(input logic [LVL_W-1:0] code);
        return (code == '0) ? LVL_W'(1) : code;
    endfunction

endpackage

// File: rtl/intc3_reqreg.sv
module intc3_reqreg #(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_req_i,
    input  logic [NUM_SRC-1:0] src_cont_i,
    input  logic               ack_i,
    input  logic [IDX_W-1:0]   ack_idx_i,
    input  logic               clr_i,
    input  logic [NUM_SRC-1:0] clr_bits_i,
    output logic [NUM_SRC-1:0] req_o
);
    logic [NUM_SRC-1:0] req_q;
    logic [NUM_SRC-1:0] req_d;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        logic ack_hit;
        logic clr_hit;
        assign ack_hit = ack_i && (ack_idx_i == IDX_W'(i));
        assign clr_hit = clr_i && clr_bits_i[i];
        always_comb begin
            if (src_cont_i[i]) begin
                // held line: only a clear knocks the bit down, for one cycle
                req_d[i] = clr_hit ? 1'b0 : (req_q[i] | src_req_i[i]);
            end else begin
                // pulse line: a fresh pulse beats ack and clear
                req_d[i] = src_req_i[i] | (req_q[i] & ~ack_hit & ~clr_hit);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) req_q <= '0;
        else         req_q <= req_d;
    end

    assign req_o = req_q;
endmodule

// File: rtl/intc3_arb.sv
module intc3_arb
    import intc3_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int IDX_W   = 4
) (
    input  logic [NUM_SRC-1:0]       req_i,
    input  logic [NUM_SRC-1:0]       en_i,
    input  logic [LVL_W*NUM_SRC-1:0] lvl_i,
    output logic                     found_o,
    output logic [IDX_W-1:0]         idx_o
);
    logic [LVL_W-1:0] best_lvl;

    // ascending scan with strict compare keeps the lowest index per level
    always_comb begin
        best_lvl = '0;
        idx_o    = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && en_i[i] && (eff_level(lvl_i[LVL_W*i +: LVL_W]) > best_lvl)) begin
                best_lvl = eff_level(lvl_i[LVL_W*i +: LVL_W]);
                idx_o    = IDX_W'(i);
            end
        end
        found_o = (best_lvl != '0);
    end
endmodule

// File: rtl/intc3_top.sv
module intc3_top
    import intc3_pkg::*;
#(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [NUM_SRC-1:0]       src_req_i,
    input  logic [NUM_SRC-1:0]       src_cont_i,
    input  logic [NUM_SRC-1:0]       src_en_i,
    input  logic [2*NUM_SRC-1:0]     src_lvl_i,
    input  logic                     wdt_req_i,
    input  logic                     wdt_en_i,
    input  logic                     trap_i,
    input  logic                     ack_i,
    input  logic [IDX_W-1:0]         ack_idx_i,
    input  logic                     clr_i,
    input  logic [NUM_SRC-1:0]       clr_bits_i,
    output logic [NUM_SRC-1:0]       req_o,
    output logic                     irq_pending_o,
    output logic [1:0]               irq_kind_o,
    output logic [IDX_W-1:0]         irq_idx_o
);
    logic [NUM_SRC-1:0] req_q;
    logic               src_found;
    logic [IDX_W-1:0]   src_idx;
    intc3_state_e       state_q, state_d;
    logic [IDX_W-1:0]   idx_q;

    intc3_reqreg #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_reqreg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .src_req_i  (src_req_i),
        .src_cont_i (src_cont_i),
        .ack_i      (ack_i),
        .ack_idx_i  (ack_idx_i),
        .clr_i      (clr_i),
        .clr_bits_i (clr_bits_i),
        .req_o      (req_q)
    );

    intc3_arb #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .req_i   (req_q),
        .en_i    (src_en_i),
        .lvl_i   (src_lvl_i),
        .found_o (src_found),
        .idx_o   (src_idx)
    );

    // next state: most urgent eligible class, from any state
    always_comb begin
        if (trap_i)                     state_d = ST_TRAP;
        else if (wdt_req_i && wdt_en_i) state_d = ST_WDOG;
        else if (src_found)             state_d = ST_SOURCE;
        else                            state_d = ST_IDLE;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q <= '0;
        end else begin
            unique case (state_d)
                ST_SOURCE: idx_q <= src_idx;
                ST_IDLE,
                ST_WDOG,
                ST_TRAP:   idx_q <= '0;
            endcase
        end
    end

    assign req_o         = req_q;
    assign irq_kind_o    = state_q;
    assign irq_idx_o     = idx_q;
    assign irq_pending_o = (state_q != ST_IDLE);
endmodule

// File: rtl/intc3_chk.sv
module intc3_chk #(
    parameter int NUM_SRC = 16,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_SRC-1:0] src_req_i,
    input logic [NUM_SRC-1:0] src_cont_i,
    input logic [NUM_SRC-1:0] src_en_i,
    input logic               wdt_req_i,
    input logic               wdt_en_i,
    input logic               trap_i,
    input logic               ack_i,
    input logic [IDX_W-1:0]   ack_idx_i,
    input logic               clr_i,
    input logic [NUM_SRC-1:0] clr_bits_i,
    input logic [NUM_SRC-1:0] req_o,
    input logic [1:0]         irq_kind_o,
    input logic [IDX_W-1:0]   irq_idx_o
);
    logic [NUM_SRC-1:0] elig_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) elig_q <= '0;
        else         elig_q <= req_o & src_en_i;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        p_pulse_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!src_cont_i[i] && src_req_i[i]) |=> req_o[i]);
        p_ack_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!src_cont_i[i] && ack_i && (ack_idx_i == IDX_W'(i)) && !src_req_i[i]) |=> !req_o[i]);
        p_ack_cont_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (src_cont_i[i] && req_o[i] && !(clr_i && clr_bits_i[i])) |=> req_o[i]);
        p_cont_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (src_cont_i[i] && clr_i && clr_bits_i[i]) |=> !req_o[i]);
    end

    p_trap_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_i |=> (irq_kind_o == 2'd3));
    p_wdog_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trap_i && wdt_req_i && wdt_en_i) |=> (irq_kind_o == 2'd2));
    p_winner_eligible_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_kind_o == 2'd1) |-> elig_q[irq_idx_o]);
    p_idle_when_empty_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!trap_i && !(wdt_req_i && wdt_en_i) && ((req_o & src_en_i) == '0)) |=> (irq_kind_o == 2'd0));
endmodule

bind intc3_top intc3_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_req_i  (src_req_i),
    .src_cont_i (src_cont_i),
    .src_en_i   (src_en_i),
    .wdt_req_i  (wdt_req_i),
    .wdt_en_i   (wdt_en_i),
    .trap_i     (trap_i),
    .ack_i      (ack_i),
    .ack_idx_i  (ack_idx_i),
    .clr_i      (clr_i),
    .clr_bits_i (clr_bits_i),
    .req_o      (req_o),
    .irq_kind_o (irq_kind_o),
    .irq_idx_o  (irq_idx_o)
);

// File: tb/test_intc3_top.sv
`timescale 1ns/1ps
module test_intc3_top;
    localparam int N = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  src = '0, cont = 16'hFF00, en = '1, clr_bits = '0;
    logic [2*N-1:0] lvl = {N{2'b01}};
    logic          wdt = 1'b0, wdt_en = 1'b0, trap = 1'b0, ack = 1'b0, clr = 1'b0;
    logic [3:0]    ack_idx = '0;
    logic [N-1:0]  req_o;
    logic          pend;
    logic [1:0]    kind;
    logic [3:0]    idx;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;
    bit compare_on = 1'b0;
    string tag = "R1";

    logic [N-1:0] m_req = '0;
    int m_kind = 0, m_idx = 0;
    int k_t, w_t;
    bit hit_t;

    always #4 clk = ~clk;

    intc3_top #(.NUM_SRC(N)) i_intc3_top (
        .clk_i(clk), .rst_ni(rst_n), .src_req_i(src), .src_cont_i(cont),
        .src_en_i(en), .src_lvl_i(lvl), .wdt_req_i(wdt), .wdt_en_i(wdt_en),
        .trap_i(trap), .ack_i(ack), .ack_idx_i(ack_idx), .clr_i(clr),
        .clr_bits_i(clr_bits), .req_o(req_o), .irq_pending_o(pend),
        .irq_kind_o(kind), .irq_idx_o(idx)
    );

    function automatic int level_of(int s);
        int c = int'(lvl[2*s +: 2]);
        return (c == 0) ? 1 : c;
    endfunction

    // behavioural reference: decide the winner from the old register, then update it
    always @(posedge clk) begin
        if (!rst_n) begin
            m_req = '0; m_kind = 0; m_idx = 0;
        end else begin
            k_t = 0; w_t = 0; hit_t = 0;
            if (trap) k_t = 3;
            else if (wdt && wdt_en) k_t = 2;
            else begin
                for (int l = 3; l >= 1; l--) begin
                    for (int s = 0; s < N; s++) begin
                        if (!hit_t && m_req[s] && en[s] && level_of(s) == l) begin
                            hit_t = 1; k_t = 1; w_t = s;
                        end
                    end
                end
            end
            m_kind = k_t; m_idx = w_t;
            for (int s = 0; s < N; s++) begin
                if (cont[s]) begin
                    if (clr && clr_bits[s]) m_req[s] = 1'b0;
                    else if (src[s])        m_req[s] = 1'b1;
                end else begin
                    if (src[s])                                   m_req[s] = 1'b1;
                    else if ((ack && ack_idx == 4'(s)) || (clr && clr_bits[s])) m_req[s] = 1'b0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (compare_on) begin
            vectors++;
            if (req_o !== m_req || kind !== 2'(m_kind) || idx !== 4'(m_idx) || pend !== (m_kind != 0)) begin
                fails++;
                $display("FAIL %s: req=%h kind=%0d idx=%0d pend=%0d exp req=%h kind=%0d idx=%0d",
                         tag, req_o, kind, idx, pend, m_req, m_kind, m_idx);
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles exp fewer than 100000", cycles);
            summary();
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin @(negedge clk); #2; end
    endtask

    task automatic check(string t, int got, int exp, string what);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: %s got %0d exp %0d", t, what, got, exp);
        end
    endtask

    task automatic clear_all();
        src = '0; ack = 0; clr = 1; clr_bits = '1; tick(); clr = 0; clr_bits = '0; tick();
    endtask

    initial begin
        tick(3);
        check("R1", int'(req_o), 0, "req_o in reset");
        check("R1", int'(kind), 0, "kind in reset");
        check("R1", int'(pend), 0, "pending in reset");
        rst_n = 1; compare_on = 1;
        tick();
        check("R1", int'(idx), 0, "idx after reset");
        check("R1", int'(pend), 0, "pending after reset");

        tag = "R12";
        src[5] = 1; tick(); src[5] = 0;
        check("R2", int'(req_o[5]), 1, "pulse latched");
        check("R12", int'(pend), 0, "pending one edge after latch");
        tick();
        check("R12", int'(pend), 1, "pending two edges after pulse");
        check("R12", int'(idx), 5, "winner index");
        tag = "R2"; tick(2);
        check("R2", int'(req_o[5]), 1, "pulse bit held");

        tag = "R3";
        ack = 1; ack_idx = 5; tick(); ack = 0;
        check("R3", int'(req_o[5]), 0, "ack clears pulse bit");
        src[9] = 1; tick(2);
        ack = 1; ack_idx = 9; tick(); ack = 0;
        check("R3", int'(req_o[9]), 1, "ack keeps continuous bit");

        tag = "R5";
        clr = 1; clr_bits = 16'h0200; tick(); clr = 0; clr_bits = '0;
        check("R5", int'(req_o[9]), 0, "continuous bit dips");
        tick();
        check("R5", int'(req_o[9]), 1, "continuous bit returns");

        tag = "R6";
        src[9] = 0; tick(3);
        check("R6", int'(req_o[9]), 1, "bit held after line drop");
        clr = 1; clr_bits = 16'h0200; tick(); clr = 0; clr_bits = '0; tick(3);
        check("R6", int'(req_o[9]), 0, "bit cleared for good");

        tag = "R4";
        src[1] = 1; tick(); src[1] = 0; tick();
        clr = 1; clr_bits = 16'h0002; tick(); clr = 0; clr_bits = '0;
        check("R4", int'(req_o[1]), 0, "clear-write on pulse bit");

        tag = "R7";
        src[4] = 1; tick();
        ack = 1; ack_idx = 4; clr = 1; clr_bits = 16'h0010; tick();
        src[4] = 0; ack = 0; clr = 0; clr_bits = '0;
        check("R7", int'(req_o[4]), 1, "new pulse beats ack and clear");
        clear_all();

        tag = "R8";
        lvl[15:14] = 2'd3; lvl[1:0] = 2'd2; lvl[13:12] = 2'd0;
        src = 16'h00C1; tick(); src = '0; tick();
        check("R8", int'(idx), 7, "level 3 wins");
        clr = 1; clr_bits = 16'h0080; tick(); clr = 0; clr_bits = '0; tick();
        check("R8", int'(idx), 0, "level 2 next");
        clr = 1; clr_bits = 16'h0001; tick(); clr = 0; clr_bits = '0;
        lvl[15:14] = 2'd1; src[7] = 1; tick(); src[7] = 0; tick();
        check("R8", int'(idx), 6, "code 0 ranks as level 1");
        lvl = {N{2'b01}};
        clear_all();

        tag = "R9";
        src = 16'h0028; tick(); src = '0; tick();
        check("R9", int'(idx), 3, "lowest index in level");
        clr = 1; clr_bits = 16'h0008; tick(); clr = 0; clr_bits = '0; tick();
        check("R9", int'(idx), 5, "next index in level");

        tag = "R10";
        src[2] = 1; tick(); src[2] = 0; tick();
        check("R10", int'(idx), 2, "index 2 wins");
        en[2] = 0; tick();
        check("R10", int'(idx), 5, "masked line skipped");
        check("R10", int'(req_o[2]), 1, "masked bit kept");
        en[2] = 1; tick();
        check("R10", int'(idx), 2, "re-enabled line wins");

        tag = "R11";
        trap = 1; wdt = 1; wdt_en = 1; tick();
        check("R11", int'(kind), 3, "trap wins");
        check("R11", int'(idx), 0, "index with trap");
        trap = 0; wdt_en = 0; tick();
        check("R11", int'(kind), 1, "disabled watchdog ignored");
        wdt_en = 1; tick();
        check("R11", int'(kind), 2, "watchdog wins");
        wdt = 0; wdt_en = 0; tick();
        check("R11", int'(kind), 1, "back to line");
        clear_all();

        tag = "R8";
        for (int c = 0; c < 3000; c++) begin
            for (int s = 0; s < 8; s++) src[s] = ($urandom_range(0, 9) == 0);
            if ($urandom_range(0, 7) == 0) src[15:8] = src[15:8] ^ (8'(1) << $urandom_range(0, 7));
            ack = ($urandom_range(0, 3) == 0); ack_idx = 4'($urandom_range(0, 15));
            clr = ($urandom_range(0, 5) == 0); clr_bits = 16'($urandom);
            if ($urandom_range(0, 19) == 0) en = 16'($urandom) | 16'h5555;
            if ($urandom_range(0, 19) == 0) lvl = $urandom;
            trap = ($urandom_range(0, 49) == 0);
            wdt = ($urandom_range(0, 19) == 0); wdt_en = ($urandom_range(0, 1) == 0);
            tick();
        end
        src = '0; ack = 0; clr = 0; trap = 0; wdt = 0;
        tick(3);
        summary();
    end
endmodule